// File: doc/BRIEF.md
# Signaling NaN Classifier and Quieter

This block takes one binary floating-point operand (single precision by default: 1 sign bit, 8 exponent bits, 23 fraction bits) and sorts it into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the block returns its quieted form and raises an invalid-operation flag. Every other operand passes through untouched.

Two conventions for the quiet-indicator bit are supported, chosen per operand by a mode input. In the 2008 convention, a set fraction MSB marks a quiet NaN. In the legacy convention, a set fraction MSB marks a signaling NaN. In legacy mode, clearing the indicator could leave an all-zero fraction, which would turn the value into an infinity. The block catches that case and sets the next fraction bit down, so the result stays a NaN.

A parameter chooses between a purely combinational path and a single output register stage. The default is registered. The block is meant to sit at the operand-read or result-write stage of a floating-point pipeline, wherever a signaling NaN must be caught and quieted.

Top module: `fp_nan_quieter`

## Requirements
- R1: With exponent field 0, the class code is 0 when the fraction is zero and 1 (denormal) otherwise. With an exponent strictly between 0 and all-ones, the class is 2 (normal). With an all-ones exponent (255) and a zero fraction, the class is 3 (infinity).
- R2: An all-ones exponent with a nonzero fraction is a NaN. Its quiet-indicator bit is the fraction MSB (word bit 22). The NaN is signaling (class 5) when nan2008_i XOR that bit equals 1, and quiet (class 4) otherwise. nan2008_i=1 selects the 2008 convention and nan2008_i=0 the legacy one.
- R3: invalid_o is 1 exactly when the operand is a signaling NaN under the current mode.
- R4: In 2008 mode, a signaling NaN is returned with fraction bit 22 set and every other bit unchanged.
- R5: In legacy mode, a signaling NaN is returned with fraction bit 22 cleared. When the remaining fraction bits are nonzero, all other bits are unchanged.
- R6: In legacy mode, if clearing bit 22 leaves the fraction all zero, fraction bit 21 is set instead, so the result is still a NaN.
- R7: Any operand that is not a signaling NaN appears on result_o unchanged, and invalid_o is 0.
- R8: The sign bit of result_o always equals the sign bit of the operand.
- R9: With REG_OUT=1, all outputs follow the operand and mode one clock edge later. While rst_n is low, the outputs read class 0, result 0 and invalid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| operand_i | input | 1+EXP_W+FRAC_W | Floating-point operand to classify |
| nan2008_i | input | 1 | Quiet-bit convention: 1 = 2008, 0 = legacy |
| class_o | output | 3 | Class code: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| result_o | output | 1+EXP_W+FRAC_W | Quieted NaN, or the operand passed through |
| invalid_o | output | 1 | Invalid-operation flag, raised for a signaling NaN |

## Verification
In the default registered configuration, all three results for an operand are due on the first rising edge after it is applied. The bench drives every operand on a falling edge, waits through exactly one rising edge, and compares on the next falling edge. It also samples once just before that rising edge to confirm that the new values have not yet appeared. The sweep crosses both signs and both modes with boundary exponents (0, 1, mid-range, 254, 255) and with fraction patterns aimed at the indicator bit, the bit below it and the all-zero-remainder case.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO   = 3'd0,
      CLS_DENORM = 3'd1,
      CLS_NORMAL = 3'd2,
      CLS_INF    = 3'd3,
      CLS_QNAN   = 3'd4,
      CLS_SNAN   = 3'd5
   } fp_class_e;

   localparam int CLASS_W = 3;

endpackage

// File: rtl/fpq_classify.sv
module fpq_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              nan2008_i,
   output fpq_pkg::fp_class_e cls_o,
   output logic              snan_o
);
   import fpq_pkg::*;

   localparam int QBIT = FRAC_W - 1;

   logic exp_zero, exp_ones, frac_zero, qbit, is_nan;

   always_comb begin
      exp_zero  = (exp_i == '0);
      exp_ones  = (exp_i == '1);
      frac_zero = (frac_i == '0);
      qbit      = frac_i[QBIT];
      is_nan    = exp_ones && !frac_zero;
      // signaling when the convention bit and the quiet indicator differ in sense
      snan_o    = is_nan && (nan2008_i ^ qbit);
   end

   always_comb begin
      if (exp_zero)      cls_o = frac_zero ? CLS_ZERO : CLS_DENORM;
      else if (!exp_ones) cls_o = CLS_NORMAL;
      else if (frac_zero) cls_o = CLS_INF;
      else               cls_o = snan_o ? CLS_SNAN : CLS_QNAN;
   end

   // R2: a signaling NaN always carries an all-ones exponent and nonzero fraction
   always_comb begin
      if (snan_o) a_r2_snan_is_nan : assert (exp_i == '1 && frac_i != '0);
   end

endmodule

// File: rtl/fpq_quiet.sv
module fpq_quiet #(
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              nan2008_i,
   output logic [FRAC_W-1:0] frac_o
);
   localparam int QBIT = FRAC_W - 1;
   localparam int FIXB = FRAC_W - 2;

   logic [FRAC_W-1:0] q_mask, fix_mask, cleared;

   always_comb begin
      q_mask   = '0;
      q_mask[QBIT] = 1'b1;
      fix_mask = '0;
      fix_mask[FIXB] = 1'b1;
      cleared  = frac_i & ~q_mask;
      if (nan2008_i)             frac_o = frac_i | q_mask;
      else if (cleared == '0)    frac_o = fix_mask;
      else                       frac_o = cleared;
   end

endmodule

// File: rtl/fpq_outstage.sv
module fpq_outstage #(
   parameter int  WORD_W  = 32,
   parameter bit  REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cls_d,
   input  logic [WORD_W-1:0] res_d,
   input  logic              inv_d,
   output logic [2:0]        cls_q,
   output logic [WORD_W-1:0] res_q,
   output logic              inv_q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cls_q <= '0;
               res_q <= '0;
               inv_q <= 1'b0;
            end else begin
               cls_q <= cls_d;
               res_q <= res_d;
               inv_q <= inv_d;
            end
         end
      end else begin : g_comb
         assign cls_q = cls_d;
         assign res_q = res_d;
         assign inv_q = inv_d;
      end
   endgenerate

endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [EXP_W+FRAC_W:0]     operand_i,
   input  logic                      nan2008_i,
   output logic [2:0]                class_o,
   output logic [EXP_W+FRAC_W:0]     result_o,
   output logic                      invalid_o
);
   import fpq_pkg::*;

   localparam int WORD_W = 1 + EXP_W + FRAC_W;
   localparam int SGN    = WORD_W - 1;
   localparam int QBIT   = FRAC_W - 1;

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fp_nan_quieter: FRAC_W must be at least 2");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("fp_nan_quieter: EXP_W must be at least 2");
      end
   endgenerate

   logic              sgn;
   logic [EXP_W-1:0]  expf;
   logic [FRAC_W-1:0] frac, frac_q;
   fp_class_e         cls;
   logic              snan;
   logic [WORD_W-1:0] res_d;

   assign sgn  = operand_i[SGN];
   assign expf = operand_i[SGN-1 -: EXP_W];
   assign frac = operand_i[FRAC_W-1:0];

   fpq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
      .exp_i    (expf),
      .frac_i   (frac),
      .nan2008_i(nan2008_i),
      .cls_o    (cls),
      .snan_o   (snan)
   );

   fpq_quiet #(.FRAC_W(FRAC_W)) u_quiet (
      .frac_i   (frac),
      .nan2008_i(nan2008_i),
      .frac_o   (frac_q)
   );

   assign res_d = snan ? {sgn, expf, frac_q} : operand_i;

   fpq_outstage #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .cls_d(cls),
      .res_d(res_d),
      .inv_d(snan),
      .cls_q(class_o),
      .res_q(result_o),
      .inv_q(invalid_o)
   );

   // Reference copies of the stimulus aligned with the outputs, for assertions.
   logic [WORD_W-1:0] chk_op;
   logic              chk_mode, chk_ok;

   generate
      if (REG_OUT) begin : g_chk_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chk_ok   <= 1'b0;
               chk_op   <= '0;
               chk_mode <= 1'b0;
            end else begin
               chk_ok   <= 1'b1;
               chk_op   <= operand_i;
               chk_mode <= nan2008_i;
            end
         end
      end else begin : g_chk_comb
         assign chk_ok   = 1'b1;
         assign chk_op   = operand_i;
         assign chk_mode = nan2008_i;
      end
   endgenerate

   a_r3_inv_means_snan : assert property (@(posedge clk) disable iff (!rst_n)
      chk_ok |-> (invalid_o == (class_o == 3'd5)));

   a_r8_sign_kept : assert property (@(posedge clk) disable iff (!rst_n)
      chk_ok |-> (result_o[SGN] == chk_op[SGN]));

   a_r7_pass_through : assert property (@(posedge clk) disable iff (!rst_n)
      (chk_ok && !invalid_o) |-> (result_o == chk_op));

   a_r4_set_qbit : assert property (@(posedge clk) disable iff (!rst_n)
      (chk_ok && invalid_o && chk_mode) |-> result_o[QBIT]);

   a_r5_clear_qbit : assert property (@(posedge clk) disable iff (!rst_n)
      (chk_ok && invalid_o && !chk_mode) |-> !result_o[QBIT]);

   a_r6_stays_nan : assert property (@(posedge clk) disable iff (!rst_n)
      (chk_ok && invalid_o) |->
         (result_o[SGN-1 -: EXP_W] == '1 && result_o[FRAC_W-1:0] != '0));

endmodule

// File: tb/fp_nan_quieter_tb.sv
module fp_nan_quieter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] operand_i = '0;
   logic        nan2008_i = 1'b0;
   logic [2:0]  class_o;
   logic [31:0] result_o;
   logic        invalid_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fp_nan_quieter u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .operand_i(operand_i),
      .nan2008_i(nan2008_i),
      .class_o  (class_o),
      .result_o (result_o),
      .invalid_o(invalid_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%h mode=%0b actual=%h expected=%h", req, operand_i, nan2008_i, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] op, input logic mode);
      logic [7:0]  e;
      logic [22:0] f, cl, qf;
      logic        sn;
      logic [2:0]  ec;
      logic [31:0] er;
      string       rtag, ctag;
      e  = op[30:23];
      f  = op[22:0];
      sn = (e == 8'hFF) && (f != 0) && (mode ^ f[22]);
      if (e == 0)          begin ec = (f == 0) ? 3'd0 : 3'd1; ctag = "R1"; end
      else if (e != 8'hFF) begin ec = 3'd2; ctag = "R1"; end
      else if (f == 0)     begin ec = 3'd3; ctag = "R1"; end
      else                 begin ec = sn ? 3'd5 : 3'd4; ctag = "R2"; end
      cl = f & 23'h3FFFFF;
      if (!sn)       begin qf = f; rtag = "R7"; end
      else if (mode) begin qf = f | 23'h400000; rtag = "R4"; end
      else if (cl == 0) begin qf = 23'h200000; rtag = "R6"; end
      else           begin qf = cl; rtag = "R5"; end
      er = {op[31], e, qf};
      @(negedge clk);
      operand_i = op;
      nan2008_i = mode;
      @(posedge clk);
      @(negedge clk);
      check(ctag, {29'd0, class_o}, {29'd0, ec});
      check(rtag, result_o, er);
      check("R3", {31'd0, invalid_o}, {31'd0, sn});
      check("R8", {31'd0, result_o[31]}, {31'd0, op[31]});
   endtask

   initial begin
      automatic logic [7:0]  exps [5]  = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
      automatic logic [22:0] fracs [8] = '{23'h000000, 23'h000001, 23'h400000, 23'h400001,
                                           23'h200000, 23'h7FFFFF, 23'h3FFFFF, 23'h600000};
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      check("R9", {29'd0, class_o}, 32'd0);
      check("R9", result_o, 32'd0);
      check("R9", {31'd0, invalid_o}, 32'd0);
      rst_n = 1'b1;

      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 2; s++)
            for (int ei = 0; ei < 5; ei++)
               for (int fi = 0; fi < 8; fi++)
                  apply({s[0], exps[ei], fracs[fi]}, m[0]);

      // NaN sweep over the top fraction bits with assorted low bits
      for (int m = 0; m < 2; m++)
         for (int t = 0; t < 16; t++)
            for (int lo = 0; lo < 3; lo++)
               apply({t[0], 8'hFF, t[3:0], (lo == 0) ? 19'd0 : (lo == 1) ? 19'd1 : 19'h7FFFF}, m[0]);

      // R9: one-edge latency, new values must not show before the edge
      apply(32'h3F800000, 1'b1);
      @(negedge clk);
      operand_i = 32'h7FC00000;
      nan2008_i = 1'b0;
      #3;
      check("R9", {31'd0, invalid_o}, 32'd0);
      check("R9", result_o, 32'h3F800000);
      @(posedge clk);
      @(negedge clk);
      check("R9", {31'd0, invalid_o}, 32'd1);
      check("R6", result_o, 32'h7FA00000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule